// File: doc/BRIEF.md
# Multi-cycle 16-bit processor core

A small non-pipelined processor that runs one 16-bit instruction at a time through a fixed sequence of six timing states. Three of these states fetch the instruction. The first copies the program counter into an address latch. The second waits for the memory reply, captures the word, and steps the program counter with its own incrementer in that same cycle. The third moves the captured word into the instruction register. Register-mode ALU instructions then read two source registers in T3. In T4 they compute the result and the Z/C/S/V flags, and in T5 they write the destination register. Jumps and branches finish in T3.

Control is hardwired. A conditional branch loads the program counter only when the decode line for that branch and the matching Z condition are both true. Otherwise the program counter keeps the value it received from the fetch increment. The core reads memory through a single request/ready port. It shows its register writes, program counter, flags and halt status on output ports, so a system or a bench can follow its execution.

Top module: `cpu16_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0, flags_o is 0000, halted_o, mem_req_o and wb_valid_o are 0. All 16 registers read as 0 after reset.
- R2: Fetch uses three states. mem_req_o is high in the second fetch state with mem_addr_o equal to the program counter, and both stay unchanged until mem_ready_i is sampled high. In that cycle the word on mem_rdata_i is captured and the program counter advances by one, wrapping from the top address to 0.
- R3: The opcode is bits [15:12]. Register mode places source A in [11:8], source B in [7:4] and destination in [3:0]. Immediate mode places the destination in [11:8] and an 8-bit immediate in [7:0].
- R4: ALU opcodes are 0001 ADD, 0010 SUB (A minus B), 0011 AND, 0100 OR and 0101 XOR. In the sixth state of the instruction, the 16-bit result is written to the destination and shown on wb_valid_o, wb_addr_o and wb_data_o.
- R5: An ALU instruction sets flags_o = {Z,C,S,V}. Z means the result is zero and S is result bit 15. For ADD, C is the carry out; for SUB, C is 1 when there is no borrow (A >= B unsigned). V is signed overflow. AND, OR and XOR clear C and V.
- R6: Flags change only in the ALU state of an ALU instruction. Load, jump, branch, NOP and halt instructions leave them unchanged.
- R7: Opcode 0110 loads the zero-extended 8-bit immediate into the immediate-mode destination register.
- R8: Opcode 1010 jumps unconditionally to the zero-extended immediate.
- R9: Opcode 1011 branches to the immediate only when Z is 1, and opcode 1100 only when Z is 0. A branch that is not taken leaves the incremented program counter.
- R10: Jumps, branches and NOPs return to the first fetch state right after the decode/operand state. ALU and load instructions use all six states.
- R11: Opcode 1111 stops the sequencer until reset. halted_o is high from the cycle after its decode state, no further memory requests are made, and pc_o and the registers hold.
- R12: Opcode 0000 and every unassigned encoding act as NOP: no register write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Instruction read request |
| mem_addr_o | output | ADDR_W | Read word address |
| mem_rdata_i | input | DATA_W | Instruction word returned by memory |
| mem_ready_i | input | 1 | Read data valid this cycle |
| pc_o | output | ADDR_W | Program counter |
| flags_o | output | 4 | {Z,C,S,V} |
| halted_o | output | 1 | Core stopped by a halt instruction |
| wb_valid_o | output | 1 | Register write this cycle |
| wb_addr_o | output | 4 | Written register index |
| wb_data_o | output | DATA_W | Written value |

## Verification
The memory capture and the program counter step happen in the same cycle: the one in which a pending request meets mem_ready_i. The bench adds wait states to the read reply so that the request stays held over several cycles. It then checks that the program counter advanced exactly once per fetch and that the instruction fetched was the one at the old address. The halt timing, the wrap from the top address to 0 and each taken or skipped branch are judged from the write trace, the final pc_o and the number of cycles before halted_o rises.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  typedef enum logic [2:0] {
    ST_T0, ST_T1, ST_T2, ST_T3, ST_T4, ST_T5, ST_HALT
  } state_e;

  localparam logic [3:0] OP_NOP = 4'h0;
  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_SUB = 4'h2;
  localparam logic [3:0] OP_AND = 4'h3;
  localparam logic [3:0] OP_OR  = 4'h4;
  localparam logic [3:0] OP_XOR = 4'h5;
  localparam logic [3:0] OP_LDI = 4'h6;
  localparam logic [3:0] OP_JMP = 4'hA;
  localparam logic [3:0] OP_BEQ = 4'hB;
  localparam logic [3:0] OP_BNE = 4'hC;
  localparam logic [3:0] OP_HLT = 4'hF;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASS
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic v;
  } flags_t;
endpackage

// File: rtl/cpu16_seq.sv
module cpu16_seq
  import cpu16_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mem_ready_i,
  input  logic   long_i,    // instruction needs T4/T5
  input  logic   halt_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_T0:   state_d = ST_T1;
      ST_T1:   state_d = mem_ready_i ? ST_T2 : ST_T1;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = halt_i ? ST_HALT : (long_i ? ST_T4 : ST_T0);
      ST_T4:   state_d = ST_T5;
      ST_T5:   state_d = ST_T0;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_T0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: fetch holds until memory answers
  a_r2_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T1 && !mem_ready_i) |=> state_q == ST_T1);
  // R10: short instructions go straight back to fetch
  a_r10_short_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T3 && !long_i && !halt_i) |=> state_q == ST_T0);
  // R11: halt is sticky
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> state_q == ST_HALT);
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_i,
  input  logic [IDX_W-1:0]  rb_i,
  output logic [DATA_W-1:0] da_o,
  output logic [DATA_W-1:0] db_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  assign da_o = rf_q[ra_i];
  assign db_o = rf_q[rb_i];

  // R4: a write lands in the addressed entry
  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  logic [DATA_W:0] sum, dif;

  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    res_o     = '0;
    flags_o.c = 1'b0;
    flags_o.v = 1'b0;
    unique case (op_i)
      ALU_ADD: begin
        res_o     = sum[DATA_W-1:0];
        flags_o.c = sum[DATA_W];
        flags_o.v = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (res_o[DATA_W-1] != a_i[DATA_W-1]);
      end
      ALU_SUB: begin
        res_o     = dif[DATA_W-1:0];
        flags_o.c = dif[DATA_W];  // 1 = no borrow
        flags_o.v = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (res_o[DATA_W-1] != a_i[DATA_W-1]);
      end
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      default:  res_o = b_i;
    endcase
    flags_o.z = (res_o == '0);
    flags_o.s = res_o[DATA_W-1];
  end

  // R5: bitwise ops never report carry or overflow
  always_comb begin
    if (op_i == ALU_AND || op_i == ALU_OR || op_i == ALU_XOR)
      a_r5_logic_no_cv: assert (!flags_o.c && !flags_o.v);
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NREG   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [3:0]        flags_o,
  output logic              halted_o,
  output logic              wb_valid_o,
  output logic [3:0]        wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int unsigned IDX_W = $clog2(NREG);
  localparam int unsigned IMM_W = 8;

  state_e            state;
  logic [ADDR_W-1:0] pc_q, mar_q, pc_inc, imm_addr;
  logic [DATA_W-1:0] mdr_q, ir_q, opa_q, opb_q, res_q, imm_data;
  logic [DATA_W-1:0] rd_a, rd_b, alu_res;
  flags_t            flags_q, alu_flags;
  logic [3:0]        opc;
  logic              is_alu, is_ldi, is_halt, take_br;
  alu_op_e           alu_op;
  logic [IDX_W-1:0]  wr_idx;

  assign opc      = ir_q[15:12];
  assign imm_data = {{(DATA_W-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};
  assign pc_inc   = pc_q + ADDR_W'(1);  // dedicated incrementer

  if (ADDR_W > IMM_W) begin : g_imm_wide
    assign imm_addr = {{(ADDR_W-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};
  end else begin : g_imm_narrow
    assign imm_addr = ir_q[ADDR_W-1:0];
  end

  // hardwired decode
  always_comb begin
    is_alu = 1'b1;
    alu_op = ALU_PASS;
    unique case (opc)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      OP_OR:   alu_op = ALU_OR;
      OP_XOR:  alu_op = ALU_XOR;
      default: is_alu = 1'b0;
    endcase
  end

  assign is_ldi  = (opc == OP_LDI);
  assign is_halt = (opc == OP_HLT);
  assign take_br = (opc == OP_JMP)
                 | ((opc == OP_BEQ) &  flags_q.z)
                 | ((opc == OP_BNE) & ~flags_q.z);
  assign wr_idx  = is_ldi ? ir_q[11:8] : ir_q[3:0];

  cpu16_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_ready_i (mem_ready_i),
    .long_i      (is_alu | is_ldi),
    .halt_i      (is_halt),
    .state_o     (state)
  );

  cpu16_regfile #(.NREG(NREG), .DATA_W(DATA_W)) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ir_q[11:8]),
    .rb_i   (ir_q[7:4]),
    .da_o   (rd_a),
    .db_o   (rd_b),
    .we_i   (state == ST_T5),
    .wa_i   (wr_idx),
    .wd_i   (res_q)
  );

  cpu16_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i    (alu_op),
    .a_i     (opa_q),
    .b_i     (opb_q),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      unique case (state)
        ST_T0: mar_q <= pc_q;
        ST_T1: if (mem_ready_i) begin
          mdr_q <= mem_rdata_i;
          pc_q  <= pc_inc;
        end
        ST_T2: ir_q <= mdr_q;
        ST_T3: begin
          opa_q <= rd_a;
          opb_q <= is_ldi ? imm_data : rd_b;
          if (take_br) pc_q <= imm_addr;  // decode line AND flag
        end
        ST_T4: begin
          res_q <= alu_res;
          if (is_alu) flags_q <= alu_flags;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o  = (state == ST_T1);
  assign mem_addr_o = mar_q;
  assign pc_o       = pc_q;
  assign flags_o    = flags_q;
  assign halted_o   = (state == ST_HALT);
  assign wb_valid_o = (state == ST_T5);
  assign wb_addr_o  = 4'(wr_idx);
  assign wb_data_o  = res_q;

  // R2: pc steps once when the read completes
  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_T1 && mem_ready_i) |=> pc_q == $past(pc_q) + ADDR_W'(1));
  // R2: address held while waiting
  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_T1 && !mem_ready_i) |=> $stable(mem_addr_o));
  // R6: flags move only out of T4
  a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_T4) |=> $stable(flags_q));
  // R8: jump loads the immediate
  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_T3 && opc == OP_JMP) |=> pc_q == $past(imm_addr));
  // R9: untaken branch keeps the incremented pc
  a_r9_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_T3 && opc == OP_BEQ && !flags_q.z) |=> $stable(pc_q));
  // R11: halted core holds pc and makes no requests
  a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(pc_q) && !mem_req_o));
endmodule

// File: tb/test_cpu16_core.sv
module test_cpu16_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ready = 1'b0, halted, wb_valid;
  logic [7:0]  mem_addr, pc;
  logic [15:0] mem_rdata, wb_data;
  logic [3:0]  flags, wb_addr;

  logic [15:0] mem [256];
  int          wait_cycles = 0;
  int          wait_cnt = 0;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  int          wb_cnt = 0;
  logic        wb_seen [16];
  logic [15:0] wb_val  [16];

  always #10 clk = ~clk;  // 50 MHz

  cpu16_core i_cpu16_core (
    .clk_i (clk), .rst_ni (rst_n),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr),
    .mem_rdata_i (mem_rdata), .mem_ready_i (mem_ready),
    .pc_o (pc), .flags_o (flags), .halted_o (halted),
    .wb_valid_o (wb_valid), .wb_addr_o (wb_addr), .wb_data_o (wb_data)
  );

  assign mem_rdata = mem[mem_addr];

  // memory reply with programmable wait states
  always @(negedge clk) begin
    if (mem_req && wait_cnt < wait_cycles) begin
      wait_cnt++;
      mem_ready = 1'b0;
    end else if (mem_req) begin
      mem_ready = 1'b1;
    end else begin
      mem_ready = 1'b0;
      wait_cnt = 0;
    end
  end

  // write-back trace
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      wb_seen[wb_addr] = 1'b1;
      wb_val[wb_addr]  = wb_data;
      wb_cnt++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [15:0] rr(logic [3:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] d);
    return {op, a, b, d};
  endfunction
  function automatic logic [15:0] im(logic [3:0] op, logic [3:0] d, logic [7:0] v);
    return {op, d, v};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      wb_seen[i] = 1'b0;
      wb_val[i]  = 16'h0;
    end
    wb_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(string req);
    int n = 0;
    do_reset();
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 16'(halted), 16'h1);
  endtask

  // {imm_a, imm_b, opcode, result, flags ZCSV}
  localparam logic [39:0] VEC [10] = '{
    {8'h05, 8'h07, 4'h1, 16'h000C, 4'b0000},
    {8'h07, 8'h05, 4'h2, 16'h0002, 4'b0100},
    {8'h05, 8'h05, 4'h2, 16'h0000, 4'b1100},
    {8'h05, 8'h07, 4'h2, 16'hFFFE, 4'b0010},
    {8'hF0, 8'h3C, 4'h3, 16'h0030, 4'b0000},
    {8'hF0, 8'h0F, 4'h3, 16'h0000, 4'b1000},
    {8'hF0, 8'h3C, 4'h4, 16'h00FC, 4'b0000},
    {8'hAA, 8'hAA, 4'h5, 16'h0000, 4'b1000},
    {8'hFF, 8'h01, 4'h1, 16'h0100, 4'b0000},
    {8'h00, 8'h00, 4'h1, 16'h0000, 4'b1000}
  };

  initial begin
    clear_mem();
    // R1: reset state
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pc", 16'(pc), 16'h0);
    chk("R1 flags", 16'(flags), 16'h0);
    chk("R1 outs", {13'b0, halted, mem_req, wb_valid}, 16'h0);

    // R3 R4 R5 R7: vector walk, LDI R1,a; LDI R2,b; op R3,R1,R2; HLT
    for (int v = 0; v < 10; v++) begin
      clear_mem();
      mem[0] = im(4'h6, 4'h1, VEC[v][39:32]);
      mem[1] = im(4'h6, 4'h2, VEC[v][31:24]);
      mem[2] = rr(VEC[v][23:20], 4'h1, 4'h2, 4'h3);
      mem[3] = 16'hF000;
      run("R11 halt reached");
      chk("R7 ldi zero-extend", wb_val[2], {8'h00, VEC[v][31:24]});
      chk("R4 result", wb_val[3], VEC[v][19:4]);
      chk("R5 flags", 16'(flags), 16'(VEC[v][3:0]));
      chk("R2 final pc", 16'(pc), 16'h4);
    end

    // R2: same program with wait states, capture and increment share the ready cycle
    wait_cycles = 3;
    clear_mem();
    mem[0] = im(4'h6, 4'h1, 8'h05);
    mem[1] = im(4'h6, 4'h2, 8'h07);
    mem[2] = 16'h1123;
    mem[3] = 16'hF000;
    run("R2 halt with waits");
    chk("R2 result with waits", wb_val[3], 16'h000C);
    chk("R2 pc with waits", 16'(pc), 16'h4);
    chk("R2 write count", 16'(wb_cnt), 16'h3);

    // R10 R11: halt timing with and without wait states
    clear_mem();
    mem[0] = 16'hF000;
    wait_cycles = 0;
    do_reset();
    repeat (3) @(negedge clk);
    chk("R11 not yet halted", 16'(halted), 16'h0);
    @(negedge clk);
    chk("R11 halted after decode", 16'(halted), 16'h1);
    wait_cycles = 2;
    do_reset();
    repeat (5) @(negedge clk);
    chk("R2 stall delays halt", 16'(halted), 16'h0);
    @(negedge clk);
    chk("R2 halted after stall", 16'(halted), 16'h1);
    wait_cycles = 0;
    begin
      int reqs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (mem_req) reqs++;
      end
      chk("R11 no requests", 16'(reqs), 16'h0);
      chk("R11 pc held", 16'(pc), 16'h1);
    end

    // R5: carry out of ADD; R5: signed overflow
    clear_mem();
    mem[0] = rr(4'h2, 4'h0, 4'h2, 4'h1);   // wait: needs R2=1 first
    mem[0] = im(4'h6, 4'h2, 8'h01);
    mem[1] = rr(4'h2, 4'h0, 4'h2, 4'h1);   // R1 = 0 - 1
    mem[2] = rr(4'h1, 4'h1, 4'h2, 4'h3);   // R3 = FFFF + 1
    mem[3] = 16'hF000;
    run("R5 carry run");
    chk("R5 sub borrow value", wb_val[1], 16'hFFFF);
    chk("R5 add carry result", wb_val[3], 16'h0000);
    chk("R5 add carry flags", 16'(flags), 16'b1100);
    clear_mem();
    mem[0] = im(4'h6, 4'h1, 8'h40);
    for (int i = 1; i <= 8; i++) mem[i] = rr(4'h1, 4'h1, 4'h1, 4'h1);
    mem[9]  = rr(4'h1, 4'h1, 4'h1, 4'h3);
    mem[10] = 16'hF000;
    run("R5 overflow run");
    chk("R5 overflow result", wb_val[3], 16'h8000);
    chk("R5 overflow flags", 16'(flags), 16'b0011);

    // R8 R9 R6: BEQ taken, BNE not taken, JMP
    clear_mem();
    mem[0]  = im(4'h6, 4'h1, 8'h05);
    mem[1]  = im(4'h6, 4'h2, 8'h05);
    mem[2]  = rr(4'h2, 4'h1, 4'h2, 4'h3);
    mem[3]  = im(4'hB, 4'h0, 8'd6);
    mem[4]  = im(4'h6, 4'h4, 8'h11);
    mem[5]  = 16'hF000;
    mem[6]  = im(4'hC, 4'h0, 8'd9);
    mem[7]  = im(4'h6, 4'h5, 8'h22);
    mem[8]  = im(4'hA, 4'h0, 8'd10);
    mem[9]  = im(4'h6, 4'h6, 8'h33);
    mem[10] = im(4'h6, 4'h7, 8'h44);
    mem[11] = 16'hF000;
    run("R9 branch run A");
    chk("R9 beq taken skips", 16'(wb_seen[4]), 16'h0);
    chk("R9 bne not taken falls through", wb_val[5], 16'h0022);
    chk("R8 jmp skips", 16'(wb_seen[6]), 16'h0);
    chk("R8 jmp target runs", wb_val[7], 16'h0044);
    chk("R6 flags kept by ldi/branch", 16'(flags), 16'b1100);
    chk("R8 final pc", 16'(pc), 16'd12);

    clear_mem();
    mem[0] = im(4'h6, 4'h1, 8'h07);
    mem[1] = im(4'h6, 4'h2, 8'h05);
    mem[2] = rr(4'h2, 4'h1, 4'h2, 4'h3);
    mem[3] = im(4'hB, 4'h0, 8'd5);
    mem[4] = im(4'hC, 4'h0, 8'd6);
    mem[5] = 16'hF000;
    mem[6] = im(4'h6, 4'h8, 8'h55);
    mem[7] = 16'hF000;
    run("R9 branch run B");
    chk("R9 bne taken", wb_val[8], 16'h0055);
    chk("R9 final pc", 16'(pc), 16'd8);
    chk("R6 flags after branches", 16'(flags), 16'b0100);

    // R2 wrap, R9 on reset flags
    clear_mem();
    mem[0]   = im(4'hC, 4'h0, 8'hFE);
    mem[1]   = 16'hF000;
    mem[254] = rr(4'h2, 4'h0, 4'h0, 4'h1);
    mem[255] = 16'h0000;
    run("R2 wrap run");
    chk("R2 wrap write count", 16'(wb_cnt), 16'h1);
    chk("R2 wrap final pc", 16'(pc), 16'h2);

    // R12: unassigned opcode and NOP
    clear_mem();
    mem[0] = im(4'h6, 4'h1, 8'h03);
    mem[1] = 16'h9123;
    mem[2] = 16'h7113;
    mem[3] = 16'h0000;
    mem[4] = 16'hF000;
    run("R12 nop run");
    chk("R12 no write", 16'(wb_cnt), 16'h1);
    chk("R12 flags unchanged", 16'(flags), 16'h0);
    chk("R12 pc", 16'(pc), 16'h5);

    // R1: reset clears registers (R1 was 3); observe via ADD R3,R1,R1
    clear_mem();
    mem[0] = rr(4'h1, 4'h1, 4'h1, 4'h3);
    mem[1] = 16'hF000;
    run("R1 reg reset run");
    chk("R1 registers cleared", wb_val[3], 16'h0000);
    chk("R1 zero flag", 16'(flags), 16'b1000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule